// File: doc/BRIEF.md
# Row Scan Shift Register with Four-Level Drive Selection

This block is the row-scan half of a matrix display driver. A 160-stage shift register moves a scan bit one stage on each falling edge of the line pulse. The scan bit enters on one of two data pins and leaves, as a carry for the next cascaded device, on the other. A direction input decides which pin is the input and which is the carry output. A dual-chain input splits the register into two 80-stage halves, and the second half is fed from its own input line.

Every stage drives a 2-bit code that selects one of four drive levels. The code depends on the stage's bit, the frame alternation signal and an active-low blanking input. The analog level shifting and the output stage take this code, and both are outside this block. All logic runs on one system clock. The line pulse is sampled on that clock, and the shift happens on the clock edge where a high-to-low transition is first seen.

Top module: `scan_com_driver`

## Requirements
- R1: While `rst` is high at a clock edge, every stage clears to 0, every level code becomes 2'b01, and both `pin_a_oe` and `pin_b_oe` go low.
- R2: The register shifts exactly once for each high-to-low transition of `line_pulse` seen on consecutive clock edges. A steady level or a rising edge leaves every stage unchanged.
- R3: With `dir_rev`=0 and `dual_mode`=0, a shift loads stage 0 from `pin_a_in` and loads stage i from stage i-1. `pin_b_out` always shows stage 159, so a bit entered on pin A appears there after the 160th shift.
- R4: With `dir_rev`=1 and `dual_mode`=0, a shift loads stage 159 from `pin_b_in` and loads stage i from stage i+1. `pin_a_out` always shows stage 0.
- R5: With `dir_rev`=0 and `dual_mode`=1, stages 0..79 and 80..159 form two forward chains. Stage 0 loads from `pin_a_in` and stage 80 loads from `dual_in`.
- R6: With `dir_rev`=1 and `dual_mode`=1, stages 159..80 and 79..0 form two reverse chains. Stage 159 loads from `pin_b_in` and stage 79 loads from `dual_in`.
- R7: With `blank_n`=1, stage i's code is `level_code[2i+1:2i]`. A stage holding 1 gets 2'b00 (top level) when `frame_alt`=1 and 2'b11 (bottom level) when `frame_alt`=0. A stage holding 0 gets 2'b10 (lower-middle) when `frame_alt`=1 and 2'b01 (upper-middle) when `frame_alt`=0.
- R8: With `blank_n`=0, every code takes the value R7 gives a stage holding 0. The register contents are kept, so the selected codes return once `blank_n` goes back to 1.
- R9: The level codes are registered. They reflect the stage bits, `frame_alt` and `blank_n` as they were one clock edge earlier, so a shift shows on the codes one clock after it shows on the carry pins.
- R10: `pin_a_oe` and `pin_b_oe` are registered from `dir_rev`, one clock edge later. `dir_rev`=0 gives `pin_b_oe`=1 and `pin_a_oe`=0, and `dir_rev`=1 gives the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pulse | input | 1 | Line pulse; its falling edge advances the scan |
| dir_rev | input | 1 | 0: scan moves from pin A toward pin B; 1: reverse |
| dual_mode | input | 1 | 1: register split into two half-length chains |
| frame_alt | input | 1 | Frame alternation signal |
| blank_n | input | 1 | Active-low blanking; low forces every row to deselect |
| pin_a_in | input | 1 | Pin A input side (scan input when dir_rev=0) |
| pin_a_out | output | 1 | Pin A output side, shows stage 0 |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b_in | input | 1 | Pin B input side (scan input when dir_rev=1) |
| pin_b_out | output | 1 | Pin B output side, shows stage 159 |
| pin_b_oe | output | 1 | Pin B output enable |
| dual_in | input | 1 | Second scan input used in dual mode |
| level_code | output | 320 | Two-bit drive-level code per stage, stage i at [2i+1:2i] |

## Verification
The bench drives a bit the full 160 stages and checks that it appears on the carry pin on the 160th shift and not earlier. A chain that is off by one stage, or that takes its carry from the wrong end, would miss that shift. Both dual-mode entry points are checked, stage 80 going forward and stage 79 in reverse. A design that splits the register at the wrong stage, or that keeps feeding the second half from the first, would load the wrong stage. Blanking is released after the scan bit has sat under it. A design that cleared the register, instead of only masking the codes, would lose the selected row. A long high level and its rising edge are checked against the registered code timing, and a design that shifts on the wrong edge, or twice per pulse, would be caught there.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    LVL_TOP       = 2'b00,
    LVL_UPPER_MID = 2'b01,
    LVL_LOWER_MID = 2'b10,
    LVL_BOTTOM    = 2'b11
  } drive_lvl_t;

  // Level for one row: a selected row swings to a rail, an unselected
  // (or blanked) row sits at the middle level opposite to that rail.
  function automatic drive_lvl_t pick_level(input logic sel,
                                            input logic fr,
                                            input logic en);
    if (en && sel) return fr ? LVL_TOP : LVL_BOTTOM;
    return fr ? LVL_LOWER_MID : LVL_UPPER_MID;
  endfunction

endpackage

// File: rtl/scan_edge_detect.sv
module scan_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic fall_o
);

  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= pulse_in;
  end

  assign fall_o = pulse_q & ~pulse_in;

  // R2
  single_shift_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);

endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int STAGES = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift,
  input  logic              rev,
  input  logic              dual,
  input  logic              ser_a,
  input  logic              ser_b,
  input  logic              ser_dual,
  output logic [STAGES-1:0] q
);

  localparam int HALF = STAGES / 2;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic fwd_src;
    logic rev_src;
    logic bit_q;

    if (i == 0) begin : g_fwd_head
      assign fwd_src = ser_a;
    end else if (i == HALF) begin : g_fwd_split
      assign fwd_src = dual ? ser_dual : q[i-1];
    end else begin : g_fwd_mid
      assign fwd_src = q[i-1];
    end

    if (i == STAGES - 1) begin : g_rev_head
      assign rev_src = ser_b;
    end else if (i == HALF - 1) begin : g_rev_split
      assign rev_src = dual ? ser_dual : q[i+1];
    end else begin : g_rev_mid
      assign rev_src = q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst)        bit_q <= 1'b0;
      else if (shift) bit_q <= rev ? rev_src : fwd_src;
    end

    assign q[i] = bit_q;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(q));

  // R3
  fwd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !rev) |=> q[0] == $past(ser_a));

  // R3
  fwd_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !rev) |=> q[STAGES-1] == $past(q[STAGES-2]));

  // R4
  rev_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && rev) |=> q[STAGES-1] == $past(ser_b));

  // R5
  dual_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !rev && dual) |=> q[HALF] == $past(ser_dual));

  // R6
  dual_rev_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && rev && dual) |=> q[HALF-1] == $past(ser_dual));

endmodule

// File: rtl/scan_level_enc.sv
module scan_level_enc
  import scan_pkg::*;
#(
  parameter int STAGES = 160
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STAGES-1:0]   sel,
  input  logic                fr,
  input  logic                blank_n,
  output logic [2*STAGES-1:0] code
);

  for (genvar i = 0; i < STAGES; i++) begin : g_row
    drive_lvl_t lvl_q;

    always_ff @(posedge clk) begin
      if (rst) lvl_q <= LVL_UPPER_MID;
      else     lvl_q <= pick_level(sel[i], fr, blank_n);
    end

    assign code[2*i +: 2] = lvl_q;
  end

  // R8
  blank_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    !blank_n |=> code[1:0] == ($past(fr) ? 2'b10 : 2'b01));

  // R7
  selected_rail_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_n && sel[0]) |=> code[1:0] == ($past(fr) ? 2'b00 : 2'b11));

endmodule

// File: rtl/scan_com_driver.sv
module scan_com_driver #(
  parameter int STAGES = 160
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_pulse,
  input  logic                dir_rev,
  input  logic                dual_mode,
  input  logic                frame_alt,
  input  logic                blank_n,
  input  logic                pin_a_in,
  output logic                pin_a_out,
  output logic                pin_a_oe,
  input  logic                pin_b_in,
  output logic                pin_b_out,
  output logic                pin_b_oe,
  input  logic                dual_in,
  output logic [2*STAGES-1:0] level_code
);

  logic              shift;
  logic [STAGES-1:0] chain;
  logic              oe_a_q;
  logic              oe_b_q;

  scan_edge_detect u_edge (
    .clk      (clk),
    .rst      (rst),
    .pulse_in (line_pulse),
    .fall_o   (shift)
  );

  scan_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift    (shift),
    .rev      (dir_rev),
    .dual     (dual_mode),
    .ser_a    (pin_a_in),
    .ser_b    (pin_b_in),
    .ser_dual (dual_in),
    .q        (chain)
  );

  scan_level_enc #(.STAGES(STAGES)) u_enc (
    .clk     (clk),
    .rst     (rst),
    .sel     (chain),
    .fr      (frame_alt),
    .blank_n (blank_n),
    .code    (level_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_a_q <= 1'b0;
      oe_b_q <= 1'b0;
    end else begin
      oe_a_q <= dir_rev;
      oe_b_q <= ~dir_rev;
    end
  end

  assign pin_a_oe  = oe_a_q;
  assign pin_b_oe  = oe_b_q;
  assign pin_a_out = chain[0];
  assign pin_b_out = chain[STAGES-1];

  // R10
  pin_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(pin_a_oe && pin_b_oe));

  // R3
  carry_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !dir_rev) |=> pin_b_out == $past(chain[STAGES-2]));

endmodule

// File: tb/scan_com_driver_bench.sv
module scan_com_driver_bench;

  localparam int STAGES = 160;
  localparam int HALF   = STAGES / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_pulse = 1'b0, dir_rev = 1'b0, dual_mode = 1'b0;
  logic frame_alt = 1'b0, blank_n = 1'b1;
  logic pin_a_in = 1'b0, pin_b_in = 1'b0, dual_in = 1'b0;
  logic pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;
  logic [2*STAGES-1:0] level_code;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #5 clk = ~clk;

  scan_com_driver #(.STAGES(STAGES)) u_scan_com_driver (
    .clk(clk), .rst(rst), .line_pulse(line_pulse), .dir_rev(dir_rev),
    .dual_mode(dual_mode), .frame_alt(frame_alt), .blank_n(blank_n),
    .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
    .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
    .dual_in(dual_in), .level_code(level_code)
  );

  // Reference model
  bit       m_chain[$];
  bit [1:0] m_code[STAGES];
  bit       m_lpq, m_oea, m_oeb;

  function automatic bit [1:0] exp_lvl(bit sel, bit fr, bit en);
    if (en && sel) return fr ? 2'b00 : 2'b11;
    return fr ? 2'b10 : 2'b01;
  endfunction

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      m_chain = {};
      for (int i = 0; i < STAGES; i++) begin
        m_chain.push_back(1'b0);
        m_code[i] = 2'b01;
      end
      m_lpq = 1'b0; m_oea = 1'b0; m_oeb = 1'b0;
    end else begin
      for (int i = 0; i < STAGES; i++)
        m_code[i] = exp_lvl(m_chain[i], frame_alt, blank_n);
      m_oea = dir_rev;
      m_oeb = !dir_rev;
      if (m_lpq && !line_pulse) begin
        bit lo[$];
        bit hi[$];
        if (!dual_mode) begin
          if (!dir_rev) begin m_chain.push_front(pin_a_in); void'(m_chain.pop_back()); end
          else          begin m_chain.push_back(pin_b_in);  void'(m_chain.pop_front()); end
        end else begin
          lo = m_chain[0:HALF-1];
          hi = m_chain[HALF:STAGES-1];
          if (!dir_rev) begin
            lo.push_front(pin_a_in); void'(lo.pop_back());
            hi.push_front(dual_in);  void'(hi.pop_back());
          end else begin
            lo.push_back(dual_in);   void'(lo.pop_front());
            hi.push_back(pin_b_in);  void'(hi.pop_front());
          end
          m_chain = {lo, hi};
        end
      end
      m_lpq = line_pulse;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      bit bad;
      bad = 1'b0;
      checks++;
      for (int i = 0; i < STAGES; i++) begin
        if (!bad && level_code[2*i +: 2] !== m_code[i]) begin
          bad = 1'b1;
          $display("FAIL R7 R9 stage %0d code got %b exp %b", i, level_code[2*i +: 2], m_code[i]);
        end
      end
      if (pin_a_out !== m_chain[0] || pin_b_out !== m_chain[STAGES-1]) begin
        bad = 1'b1;
        $display("FAIL R3 R4 R5 R6 carry got a=%b b=%b exp a=%b b=%b",
                 pin_a_out, pin_b_out, m_chain[0], m_chain[STAGES-1]);
      end
      if (pin_a_oe !== m_oea || pin_b_oe !== m_oeb) begin
        bad = 1'b1;
        $display("FAIL R10 oe got a=%b b=%b exp a=%b b=%b", pin_a_oe, pin_b_oe, m_oea, m_oeb);
      end
      if (bad) errors++;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  function automatic int code_at(int i);
    return int'(level_code[2*i +: 2]);
  endfunction

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit a, bit b, bit d);
    @(negedge clk);
    pin_a_in = a; pin_b_in = b; dual_in = d; line_pulse = 1'b1;
    cycles(2);
    line_pulse = 1'b0;
    cycles(2);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [2*STAGES-1:0] snap;
    cycles(3);
    chk("R1 stage0 code", code_at(0), 1);
    chk("R1 stage159 code", code_at(159), 1);
    chk("R1 oe a", pin_a_oe, 0);
    chk("R1 oe b", pin_b_oe, 0);
    chk("R1 carry", pin_b_out, 0);
    rst = 1'b0; frame_alt = 1'b1;
    cycles(1);
    chk("R10 fwd oe b", pin_b_oe, 1);
    chk("R10 fwd oe a", pin_a_oe, 0);

    // single forward
    pulse(1, 0, 0); pulse(0, 0, 0); pulse(1, 0, 0); pulse(1, 0, 0);
    chk("R3 stage0", code_at(0), 0);
    chk("R3 stage1", code_at(1), 0);
    chk("R7 stage2 unselected fr=1", code_at(2), 2);
    chk("R3 stage3", code_at(3), 0);

    // long high level then rising edge: no shift
    @(negedge clk);
    pin_a_in = 1'b0; line_pulse = 1'b1;
    snap = level_code;
    cycles(6);
    checks++;
    if (level_code !== snap) begin
      errors++;
      $display("FAIL R2 codes moved without falling edge got %h exp %h", level_code, snap);
    end
    line_pulse = 1'b0;
    cycles(2);
    // five shifts so far; first bit now at stage 4
    for (int k = 0; k < 154; k++) pulse(0, 0, 0);
    chk("R3 carry before 160th shift", pin_b_out, 0);
    pulse(0, 0, 0);
    chk("R3 carry after 160th shift", pin_b_out, 1);
    frame_alt = 1'b0;
    cycles(2);
    chk("R7 selected fr=0", code_at(159), 3);
    chk("R7 unselected fr=0", code_at(0), 1);

    // blanking
    blank_n = 1'b0;
    cycles(2);
    chk("R8 blanked selected row", code_at(159), 1);
    cycles(5);
    blank_n = 1'b1;
    cycles(2);
    chk("R8 contents kept", code_at(159), 3);

    // single reverse
    dir_rev = 1'b1;
    cycles(1);
    chk("R10 rev oe a", pin_a_oe, 1);
    chk("R10 rev oe b", pin_b_oe, 0);
    pulse(0, 1, 0); pulse(0, 0, 0);
    chk("R4 stage159", code_at(159), 1);
    chk("R4 stage158", code_at(158), 3);

    // dual forward
    dir_rev = 1'b0; dual_mode = 1'b1; frame_alt = 1'b1;
    pulse(1, 0, 0); pulse(0, 0, 1);
    chk("R5 stage0", code_at(0), 2);
    chk("R5 stage1", code_at(1), 0);
    chk("R5 stage80", code_at(80), 0);
    chk("R5 stage81", code_at(81), 2);

    // dual reverse
    dir_rev = 1'b1;
    pulse(0, 1, 0); pulse(0, 0, 1);
    chk("R6 stage159", code_at(159), 2);
    chk("R6 stage158", code_at(158), 0);
    chk("R6 stage79", code_at(79), 0);
    chk("R6 stage78", code_at(78), 2);
    blank_n = 1'b0;
    cycles(2);
    chk("R8 blanked fr=1", code_at(79), 2);
    blank_n = 1'b1;
    cycles(3);

    finish_run();
  end

endmodule